// File: doc/BRIEF.md
# Joinable Two-Lane Pulse-Width Modulator

This block holds one even and one odd pulse-width channel. Each channel is 8 bits wide. The channels either run as two independent pulse generators, or a mode bit joins them into one 16-bit generator. Each channel takes six settings from its own inputs:

- a period value
- a duty value
- an output polarity
- a choice between edge (left) and centre alignment
- an enable
- a choice of time base

All of these settings arrive as plain input ports. The surrounding register file owns them.

The two time bases come from a shared front end. The first is the raw clock, which gives one tick per cycle. The second is a scaled tick that fires once every 2 × SCALE cycles. The front end can be frozen from outside in two ways:

- when the doze-stop setting is set and the doze input is high;
- when the freeze setting is set and the debug input is high.

While the front end is frozen, every counter and every output holds its value.

In joined mode, the bytes of period, duty and counter are split between the two channels. The even channel carries the high byte and the odd channel carries the low byte. The odd channel's settings drive the 16-bit generator, and its waveform appears on the odd output. The even output is held low.

Top module: `pwm_pair_top`

## Requirements
- R1: In edge-aligned mode an enabled channel with period P counts 0, 1, …, P-1 on its ticks and then wraps to 0. Its output is active while the count is below the duty value and inactive otherwise.
- R2: In centre-aligned mode the count climbs from 0 to P and then falls back to 0, so one period takes 2·P ticks. The output is active while the count is below the duty value.
- R3: Output polarity works per channel. Polarity 1 makes the active level high and polarity 0 makes it low. The inactive level is always the complement of the active level.
- R4: A duty value greater than or equal to the period gives a constantly active output.
- R5: A disabled channel drives its inactive level and holds its count at 0. When it is enabled again, it starts a fresh period from a count of 0.
- R6: New period and duty values take effect only when the current period ends. While the channel is disabled, they take effect immediately.
- R7: Time-base select 0 gives one tick every clock cycle. Select 1 gives one tick every 2·SCALE cycles, and a SCALE of 0 counts as 256, so the divide is 512.
- R8: With the join bit at 1, the pair acts as one 16-bit channel. Period is {period0, period1} and duty is {duty0, duty1}. The odd channel's enable, polarity, alignment and time-base select control it, and the waveform appears on out[1]. out[0] stays 0, and the even channel's own enable, polarity, alignment and time-base bits have no effect.
- R9: Any change of the join bit sends every counter back to 0.
- R10: While the doze-stop setting and the doze input are both 1, no ticks occur and counters and outputs hold their values. With the doze-stop setting at 0, the doze input has no effect.
- R11: While the freeze setting and the debug input are both 1, no ticks occur and counters and outputs hold their values. With the freeze setting at 0, the debug input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the unscaled time base |
| rstN | input | 1 | Active-low synchronous reset |
| concat | input | 1 | Join the two channels into one 16-bit channel |
| dozeStopEn | input | 1 | Allow the doze input to freeze the time base |
| dozeIn | input | 1 | Doze request |
| freezeEn | input | 1 | Allow the debug input to freeze the time base |
| debugIn | input | 1 | Debug halt request |
| scale | input | 8 | Scaled tick divisor; the tick fires every 2·scale cycles, and 0 means 256 |
| enable | input | 2 | Per-channel enable; bit 1 is the odd channel |
| clkSel | input | 2 | Per-channel time base: 0 for the raw clock, 1 for the scaled tick |
| polarity | input | 2 | Per-channel active level: 1 for high |
| centerAlign | input | 2 | Per-channel alignment: 1 for centre |
| period0 | input | 8 | Even channel period; high byte when joined |
| period1 | input | 8 | Odd channel period; low byte when joined |
| duty0 | input | 8 | Even channel duty; high byte when joined |
| duty1 | input | 8 | Odd channel duty; low byte when joined |
| pwmOut | output | 2 | Channel outputs; bit 1 carries the 16-bit waveform when joined |

## Verification
The bench targets the following failure cases:

- **Period shortened mid-run.** A design that loads a shorter period at once would wrap early, and the waveform would drift from the model.
- **Centre alignment with a period of 1.** A count that turns at the wrong place would leave a run of 3 ticks or underflow.
- **Duty equal to the period.** An off-by-one would leave a one-tick glitch at the turning point.
- **Join mode with a period above 255, with contradictory even-channel settings applied.** A design that took the wrong byte order, or listened to the even channel, would break the 16-bit pattern or let out[0] toggle.
- **SCALE of 0, and front-end freezing.** A design that treats 0 as 0 would tick far too often. A leaky freeze would let counters creep on while the front end is frozen.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  // strobes from the clock front end to the counters
  typedef struct packed {
    logic tickA;      // raw time base tick (every unfrozen cycle)
    logic tickSA;     // scaled time base tick
    logic modeClear;  // join bit changed: clear every counter
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_pair_ctrl.sv
module pwm_pair_ctrl
  import pwm_pair_pkg::*;
#(
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               concat,
  input  logic               dozeStopEn,
  input  logic               dozeIn,
  input  logic               freezeEn,
  input  logic               debugIn,
  input  logic [SCALE_W-1:0] scale,
  output pwmStrobe_t         strobe
);
  localparam int PS_W = SCALE_W + 1;

  logic [PS_W-1:0] psCnt;
  logic [PS_W-1:0] scaleEff;
  logic [PS_W:0]   limitM1;
  logic            stopNow;
  logic            saNow;
  logic            concatQ;

  always_comb begin
    scaleEff = (scale == '0) ? PS_W'(1 << SCALE_W) : {1'b0, scale};
    limitM1  = {scaleEff, 1'b0} - 1'b1;
    stopNow  = (dozeStopEn & dozeIn) | (freezeEn & debugIn);
    saNow    = !stopNow && ({1'b0, psCnt} >= limitM1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psCnt   <= '0;
      concatQ <= 1'b0;
    end else begin
      concatQ <= concat;
      if (saNow)         psCnt <= '0;
      else if (!stopNow) psCnt <= psCnt + 1'b1;
    end
  end

  assign strobe.tickA     = !stopNow;
  assign strobe.tickSA    = saNow;
  assign strobe.modeClear = (concat != concatQ);

  a_r10_r11_frozen_prescaler: assert property (@(posedge clk) disable iff (!rstN)
    stopNow |=> $stable(psCnt));
  a_r7_scaled_restart: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tickSA |=> (psCnt == '0));
  a_r7_scaled_needs_raw: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tickSA |-> strobe.tickA);
endmodule

// File: rtl/pwm_pair_chan.sv
module pwm_pair_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         en,
  input  logic         tick,
  input  logic         clear,
  input  logic         center,
  input  logic         pol,
  input  logic [W-1:0] per,
  input  logic [W-1:0] duty,
  output logic [W-1:0] cnt,
  output logic         wave
);
  logic [W-1:0] perS;
  logic [W-1:0] dutyS;
  logic         up;
  logic [W:0]   cntP1;
  logic         active;

  assign cntP1  = {1'b0, cnt} + 1'b1;
  assign active = (dutyS >= perS) || (cnt < dutyS);
  assign wave   = en ? (active ? pol : ~pol) : ~pol;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      up    <= 1'b1;
      perS  <= '0;
      dutyS <= '0;
    end else if (clear || !en) begin
      cnt   <= '0;
      up    <= 1'b1;
      perS  <= per;
      dutyS <= duty;
    end else if (tick) begin
      if (!center) begin
        up <= 1'b1;
        if (cntP1 >= {1'b0, perS}) begin
          cnt   <= '0;
          perS  <= per;
          dutyS <= duty;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (up) begin
        if (cnt >= perS) begin
          if (cnt <= W'(1)) begin
            cnt   <= '0;
            perS  <= per;
            dutyS <= duty;
          end else begin
            cnt <= cnt - 1'b1;
            up  <= 1'b0;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt == W'(1)) begin
          up    <= 1'b1;
          perS  <= per;
          dutyS <= duty;
        end
      end
    end
  end

  a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    (en && !tick && !clear) |=> ($stable(perS) && $stable(dutyS)));
  a_r2_center_ceiling: assert property (@(posedge clk) disable iff (!rstN)
    (en && center) |-> (cnt <= perS));
  a_r5_idle_count: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (cnt == '0));
endmodule

// File: rtl/pwm_pair_dp.sv
module pwm_pair_dp
  import pwm_pair_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  pwmStrobe_t      strobe,
  input  logic            concat,
  input  logic [1:0]      enable,
  input  logic [1:0]      clkSel,
  input  logic [1:0]      polarity,
  input  logic [1:0]      centerAlign,
  input  logic [CH_W-1:0] period0,
  input  logic [CH_W-1:0] period1,
  input  logic [CH_W-1:0] duty0,
  input  logic [CH_W-1:0] duty1,
  output logic [1:0]      pwmOut
);
  localparam int WIDE_W = 2 * CH_W;

  logic [CH_W-1:0]   perN [2];
  logic [CH_W-1:0]   dutyN[2];
  logic [CH_W-1:0]   cntN [2];
  logic [1:0]        waveN;
  logic [WIDE_W-1:0] cntW;
  logic              waveW;

  assign perN[0]  = period0;
  assign perN[1]  = period1;
  assign dutyN[0] = duty0;
  assign dutyN[1] = duty1;

  for (genvar i = 0; i < 2; i++) begin : g_narrow
    pwm_pair_chan #(.W(CH_W)) chan_i (
      .clk   (clk),
      .rstN  (rstN),
      .en    (enable[i] & ~concat),
      .tick  (clkSel[i] ? strobe.tickSA : strobe.tickA),
      .clear (strobe.modeClear),
      .center(centerAlign[i]),
      .pol   (polarity[i]),
      .per   (perN[i]),
      .duty  (dutyN[i]),
      .cnt   (cntN[i]),
      .wave  (waveN[i])
    );
  end

  pwm_pair_chan #(.W(WIDE_W)) wide_i (
    .clk   (clk),
    .rstN  (rstN),
    .en    (enable[1] & concat),
    .tick  (clkSel[1] ? strobe.tickSA : strobe.tickA),
    .clear (strobe.modeClear),
    .center(centerAlign[1]),
    .pol   (polarity[1]),
    .per   ({period0, period1}),
    .duty  ({duty0, duty1}),
    .cnt   (cntW),
    .wave  (waveW)
  );

  assign pwmOut[0] = concat ? 1'b0 : waveN[0];
  assign pwmOut[1] = concat ? waveW : waveN[1];

  a_r9_mode_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.modeClear |=> ((cntW == '0) && (cntN[0] == '0) && (cntN[1] == '0)));
  a_r8_even_quiet: assert property (@(posedge clk) disable iff (!rstN)
    concat |-> (pwmOut[0] == 1'b0));
endmodule

// File: rtl/pwm_pair_top.sv
module pwm_pair_top
  import pwm_pair_pkg::*;
#(
  parameter int CH_W    = 8,
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               concat,
  input  logic               dozeStopEn,
  input  logic               dozeIn,
  input  logic               freezeEn,
  input  logic               debugIn,
  input  logic [SCALE_W-1:0] scale,
  input  logic [1:0]         enable,
  input  logic [1:0]         clkSel,
  input  logic [1:0]         polarity,
  input  logic [1:0]         centerAlign,
  input  logic [CH_W-1:0]    period0,
  input  logic [CH_W-1:0]    period1,
  input  logic [CH_W-1:0]    duty0,
  input  logic [CH_W-1:0]    duty1,
  output logic [1:0]         pwmOut
);
  pwmStrobe_t strobe;

  pwm_pair_ctrl #(.SCALE_W(SCALE_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .concat    (concat),
    .dozeStopEn(dozeStopEn),
    .dozeIn    (dozeIn),
    .freezeEn  (freezeEn),
    .debugIn   (debugIn),
    .scale     (scale),
    .strobe    (strobe)
  );

  pwm_pair_dp #(.CH_W(CH_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .concat     (concat),
    .enable     (enable),
    .clkSel     (clkSel),
    .polarity   (polarity),
    .centerAlign(centerAlign),
    .period0    (period0),
    .period1    (period1),
    .duty0      (duty0),
    .duty1      (duty1),
    .pwmOut     (pwmOut)
  );
endmodule

// File: tb/pwm_pair_top_tb_top.sv
module pwm_pair_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       concat = 1'b0;
  logic       dozeStopEn = 1'b0, dozeIn = 1'b0, freezeEn = 1'b0, debugIn = 1'b0;
  logic [7:0] scale = 8'd1;
  logic [1:0] enable = 2'b00, clkSel = 2'b00, polarity = 2'b11, centerAlign = 2'b00;
  logic [7:0] period0 = 8'd0, period1 = 8'd0, duty0 = 8'd0, duty1 = 8'd0;
  logic [1:0] pwmOut;

  int total = 0;
  int bad = 0;
  string curReq = "R1";
  bit done = 0;

  // behavioural reference: lane 0/1 = narrow channels, lane 2 = joined channel
  int  mCnt[3];
  int  mPer[3];
  int  mDuty[3];
  bit  mUp[3];
  int  mPs;
  bit  mConcatQ;

  always #10 clk = ~clk;

  pwm_pair_top dut_i (
    .clk(clk), .rstN(rstN), .concat(concat), .dozeStopEn(dozeStopEn), .dozeIn(dozeIn),
    .freezeEn(freezeEn), .debugIn(debugIn), .scale(scale), .enable(enable), .clkSel(clkSel),
    .polarity(polarity), .centerAlign(centerAlign), .period0(period0), .period1(period1),
    .duty0(duty0), .duty1(duty1), .pwmOut(pwmOut)
  );

  function automatic void modelReset();
    for (int k = 0; k < 3; k++) begin
      mCnt[k] = 0; mPer[k] = 0; mDuty[k] = 0; mUp[k] = 1;
    end
    mPs = 0; mConcatQ = 0;
  endfunction

  function automatic void laneStep(int k, bit en, bit tk, bit clr, bit ctr, int per, int dut);
    if (clr || !en) begin
      mCnt[k] = 0; mUp[k] = 1; mPer[k] = per; mDuty[k] = dut;
    end else if (tk) begin
      if (!ctr) begin
        mUp[k] = 1;
        if (mCnt[k] + 1 >= mPer[k]) begin mCnt[k] = 0; mPer[k] = per; mDuty[k] = dut; end
        else mCnt[k]++;
      end else if (mUp[k]) begin
        if (mCnt[k] < mPer[k]) mCnt[k]++;
        else if (mCnt[k] <= 1) begin mCnt[k] = 0; mPer[k] = per; mDuty[k] = dut; end
        else begin mCnt[k]--; mUp[k] = 0; end
      end else begin
        if (mCnt[k] == 1) begin mUp[k] = 1; mPer[k] = per; mDuty[k] = dut; end
        mCnt[k]--;
      end
    end
  endfunction

  function automatic void modelStep();
    bit stop, ta, tsa, clr;
    int lim;
    stop = (dozeStopEn && dozeIn) || (freezeEn && debugIn);
    lim  = 2 * ((scale == 0) ? 256 : int'(scale));
    ta   = !stop;
    tsa  = ta && (mPs >= lim - 1);
    if (tsa) mPs = 0; else if (ta) mPs++;
    clr = (concat != mConcatQ);
    mConcatQ = concat;
    laneStep(0, enable[0] && !concat, clkSel[0] ? tsa : ta, clr, centerAlign[0], period0, duty0);
    laneStep(1, enable[1] && !concat, clkSel[1] ? tsa : ta, clr, centerAlign[1], period1, duty1);
    laneStep(2, enable[1] && concat, clkSel[1] ? tsa : ta, clr, centerAlign[1],
             {period0, period1}, {duty0, duty1});
  endfunction

  function automatic bit laneWave(int k, bit en, bit pol);
    bit act;
    act = (mDuty[k] >= mPer[k]) || (mCnt[k] < mDuty[k]);
    return en ? (act ? pol : !pol) : !pol;
  endfunction

  function automatic logic [1:0] modelOut();
    logic [1:0] o;
    if (concat) begin
      o[0] = 1'b0;
      o[1] = laneWave(2, enable[1], polarity[1]);
    end else begin
      o[0] = laneWave(0, enable[0], polarity[0]);
      o[1] = laneWave(1, enable[1], polarity[1]);
    end
    return o;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pwmOut actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // advance n cycles: model follows each rising edge, compare at the falling edge
  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelStep();
      @(negedge clk);
      check(curReq, pwmOut, modelOut());
    end
  endtask

  initial begin
    logic [1:0] held;
    int toggles;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R5: after reset both channels disabled, polarity 1 -> outputs low
    check("R5", pwmOut, 2'b00);

    // R1: two independent edge-aligned channels
    curReq = "R1";
    period0 = 8'd5; duty0 = 8'd2; period1 = 8'd7; duty1 = 8'd3; enable = 2'b11;
    run(40);

    // R3: odd channel active low
    curReq = "R3";
    polarity = 2'b01;
    run(20);

    // R2: centre aligned, including period 1 on the odd channel
    curReq = "R2";
    polarity = 2'b11; centerAlign = 2'b11; period0 = 8'd4; duty0 = 8'd1;
    period1 = 8'd1; duty1 = 8'd1;
    run(30);
    period1 = 8'd6; duty1 = 8'd6;  // R4: duty equal to period in centre mode
    curReq = "R4";
    run(40);

    // R4: duty above period, edge aligned
    centerAlign = 2'b00; period1 = 8'd6; duty1 = 8'd9;
    run(20);
    check("R4", pwmOut & 2'b10, 2'b10);

    // R6: shorten period mid-run; takes effect at period end only
    curReq = "R6";
    period0 = 8'd10; duty0 = 8'd5;
    run(13);
    period0 = 8'd3; duty0 = 8'd1;
    run(30);

    // R7: scaled tick with scale 2, then scale 0 (=256)
    curReq = "R7";
    clkSel = 2'b11; scale = 8'd2; period0 = 8'd3; duty0 = 8'd1;
    run(80);
    scale = 8'd0; period0 = 8'd2; duty0 = 8'd1;
    run(2200);

    // R5: disable the odd channel, output goes to inactive level
    curReq = "R5";
    clkSel = 2'b00; polarity = 2'b01; enable = 2'b01;
    run(10);
    check("R5", pwmOut & 2'b10, 2'b10);
    enable = 2'b11;
    run(20);

    // R8: joined mode, period 0x0104, duty 0x0064, even settings contradictory
    curReq = "R8";
    polarity = 2'b10; concat = 1'b1; period0 = 8'h01; period1 = 8'h04;
    duty0 = 8'h00; duty1 = 8'h64; enable = 2'b10; centerAlign = 2'b01; clkSel = 2'b01;
    toggles = 0;
    for (int i = 0; i < 700; i++) begin
      held = pwmOut;
      run(1);
      if (pwmOut[1] != held[1]) toggles++;
      if (pwmOut[0] !== 1'b0) check("R8", pwmOut & 2'b01, 2'b00);
    end
    total++;
    if (toggles < 4) begin bad++; $display("FAIL R8: toggles actual=%0d expected>=4", toggles); end

    // R9: drop out of joined mode and back again mid-period
    curReq = "R9";
    concat = 1'b0; enable = 2'b11; period0 = 8'd9; duty0 = 8'd4; period1 = 8'd9; duty1 = 8'd4;
    run(7);
    concat = 1'b1;
    run(30);
    concat = 1'b0;
    run(30);

    // R10: doze freeze holds outputs; doze without the enable has no effect
    curReq = "R10";
    dozeStopEn = 1'b1; dozeIn = 1'b1;
    held = pwmOut;
    run(20);
    check("R10", pwmOut, held);
    dozeStopEn = 1'b0;
    run(20);

    // R11: debug freeze
    curReq = "R11";
    dozeIn = 1'b0; freezeEn = 1'b1; debugIn = 1'b1;
    held = pwmOut;
    run(15);
    check("R11", pwmOut, held);
    freezeEn = 1'b0;
    run(20);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule